// File: doc/BRIEF.md
# Configuration Header Checksum and GUID Validator

This block watches a configuration header arriving one byte per accepted beat from a serial memory and judges it on the fly. A running modulo-256 sum is kept while the bytes arrive, so when the final beat lands the block knows at once whether the stored check byte is consistent. In the same pass it collects the eight identifier bytes and a guid-count byte, screens the identifier for the two forbidden patterns, repairs identifiers written in the older packed layout, and flags the one identifier value known to be a factory placeholder.

A unit that is not the first in a group does not need its own header: when its unit index is nonzero and within the count published by the base unit, it takes the base identifier, adds its index to the lowest byte, and lets the carry ripple no further than two bytes up. If the ripple would need to go further, the derivation fails, the identifier is forced to zero and an error flag is raised. Results appear together with a one-cycle done pulse in the cycle after the last header byte and are held until the next header finishes.

Top module: `hdr_guid_check`

## Requirements
- R1: With L the byte at offset 0, S the 8-bit wrapping sum of every received byte whose offset is below L, and C the byte at offset 1, csum_ok_o is 1 exactly when the bitwise inverse of (S - C) equals C and at least L bytes were received.
- R2: Bytes at offsets at or beyond L do not enter the sum, and a stream that ends with fewer than L bytes gives csum_ok_o = 0.
- R3: Outside the derived case the header identifier (offsets 2 to 9, offset 2 the most significant byte) is valid only if csum_ok_o is 1 and the identifier is neither all zeros nor all ones; an invalid identifier gives guid_o = 0 and guid_valid_o = 0.
- R4: A valid header identifier whose bytes 0, 1 and 2 are zero is output with byte 3 moved to byte 1, byte 4 moved to byte 2, and bytes 3 and 4 cleared; other valid identifiers pass unchanged.
- R5: guid_default_o is 1 when the header identifier is valid and its received value equals 64'h0000_0011_7500_0001; it is 0 otherwise.
- R6: The derived case applies only when unit_idx_i is nonzero, base_count_i is greater than 1 and unit_idx_i is not above base_count_i; in it the header identifier is ignored.
- R7: In the derived case unit_idx_i is added to byte 7 of base_guid_i modulo 256; on overflow byte 6 is incremented, and if byte 6 was 0xFF byte 5 is incremented too; bytes 0 to 4 are copied.
- R8: If the derivation overflows with bytes 6 and 5 both 0xFF, carry_err_o = 1, guid_o = 0, guid_valid_o = 0 and guid_count_o = 0.
- R9: guid_count_o is 1 after a successful derivation, the byte at offset 10 for a valid header identifier, and 0 otherwise.
- R10: done_o is high for one cycle, the cycle after the beat carrying byte_last_i; all result outputs change only with done_o and hold until the next.
- R11: After reset all outputs are 0.
- R12: Beats with byte_valid_i low are ignored, including their data and last flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Header byte present this cycle |
| byte_data_i | input | 8 | Header byte |
| byte_last_i | input | 1 | Final header byte, qualified by byte_valid_i |
| unit_idx_i | input | UNIT_W | Index of this unit in its group |
| base_guid_i | input | 64 | Identifier of the base unit |
| base_count_i | input | 8 | Identifier count published by the base unit |
| done_o | output | 1 | One-cycle result strobe |
| csum_ok_o | output | 1 | Header check byte consistent |
| guid_o | output | 64 | Resulting identifier |
| guid_valid_o | output | 1 | guid_o is usable |
| guid_default_o | output | 1 | Identifier is the factory placeholder |
| carry_err_o | output | 1 | Derivation overflowed past byte 5 |
| guid_count_o | output | 8 | Identifier count reported for this unit |

## Verification
Every result is registered on the clock edge that accepts the last header byte, so all seven outputs are due in the following cycle together with done_o. The bench drives on the falling edge, checks done_o and the results on the falling edge right after the last beat, and one cycle later checks that done_o has dropped and the identifier has not moved. Random idle beats with junk data and a stray last flag are interleaved so that ignored beats would shift the expected values if they leaked in.

// File: rtl/hdr_guid_pkg.sv
package hdr_guid_pkg;
  typedef logic [7:0]  byte_t;
  typedef logic [63:0] guid_t;

  // byte k of an identifier, byte 0 most significant
  function automatic byte_t gbyte(guid_t g, int k);
    return g[63-8*k -: 8];
  endfunction

  function automatic guid_t set_gbyte(guid_t g, int k, byte_t b);
    guid_t r;
    r = g;
    r[63-8*k -: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/hdr_sum.sv
module hdr_sum #(
  parameter int IDX_W    = 8,
  parameter int LEN_OFS  = 0,
  parameter int CSUM_OFS = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             end_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic             ok_o
);
  localparam logic [IDX_W-1:0] LEN_IDX  = IDX_W'(LEN_OFS);
  localparam logic [IDX_W-1:0] CSUM_IDX = IDX_W'(CSUM_OFS);

  logic [7:0] sum_q, len_q, csum_q;
  logic [7:0] sum_n, len_n, csum_n, inv;
  logic [IDX_W:0] cnt;
  logic incl;

  always_comb begin
    len_n  = (idx_i == LEN_IDX)  ? byte_i : len_q;
    csum_n = (idx_i == CSUM_IDX) ? byte_i : csum_q;
    incl   = ({{(IDX_W > 8 ? IDX_W-8 : 0){1'b0}}, idx_i} < {{(IDX_W > 8 ? IDX_W-8 : 0){1'b0}}, len_n});
    sum_n  = sum_q + (incl ? byte_i : 8'h00);
    cnt    = {1'b0, idx_i} + 1'b1;
    inv    = ~(sum_n - csum_n);
    ok_o   = (inv == csum_n) && (cnt >= (IDX_W+1)'(len_n));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      len_q  <= '0;
      csum_q <= '0;
    end else if (take_i) begin
      if (end_i) begin
        sum_q  <= '0;
        len_q  <= '0;
        csum_q <= '0;
      end else begin
        sum_q  <= sum_n;
        len_q  <= len_n;
        csum_q <= csum_n;
      end
    end
  end

  // R2: a finished header leaves no residue for the next one
  a_r2_clear_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && end_i |=> sum_q == 8'h00 && len_q == 8'h00 && csum_q == 8'h00);
endmodule

// File: rtl/guid_cap.sv
module guid_cap #(
  parameter int IDX_W    = 8,
  parameter int GUID_OFS = 2,
  parameter int CNT_OFS  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             end_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic [63:0]      guid_o,
  output logic [7:0]       cnt_o
);
  localparam logic [IDX_W:0] G_LO  = (IDX_W+1)'(GUID_OFS);
  localparam logic [IDX_W:0] G_HI  = (IDX_W+1)'(GUID_OFS + 8);
  localparam logic [IDX_W-1:0] C_IDX = IDX_W'(CNT_OFS);

  logic [63:0] guid_q;
  logic [7:0]  cnt_q;
  logic        in_guid;

  always_comb begin
    in_guid = ({1'b0, idx_i} >= G_LO) && ({1'b0, idx_i} < G_HI);
    guid_o  = in_guid ? {guid_q[55:0], byte_i} : guid_q;
    cnt_o   = (idx_i == C_IDX) ? byte_i : cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guid_q <= '0;
      cnt_q  <= '0;
    end else if (take_i) begin
      guid_q <= end_i ? '0 : guid_o;
      cnt_q  <= end_i ? '0 : cnt_o;
    end
  end
endmodule

// File: rtl/guid_screen.sv
module guid_screen
  import hdr_guid_pkg::*;
#(
  parameter logic [63:0] DEFAULT_GUID = 64'h0000_0011_7500_0001
) (
  input  logic        ok_i,
  input  logic [63:0] raw_i,
  output logic        valid_o,
  output logic        dflt_o,
  output logic [63:0] guid_o
);
  logic legacy;
  guid_t fixed;

  always_comb begin
    valid_o = ok_i && (raw_i != '0) && (raw_i != '1);
    legacy  = (raw_i[63:40] == 24'h0);
    fixed   = raw_i;
    if (legacy) begin
      fixed = set_gbyte(fixed, 1, gbyte(raw_i, 3));
      fixed = set_gbyte(fixed, 2, gbyte(raw_i, 4));
      fixed = set_gbyte(fixed, 3, 8'h00);
      fixed = set_gbyte(fixed, 4, 8'h00);
    end
    guid_o = valid_o ? fixed : '0;
    dflt_o = valid_o && (raw_i == DEFAULT_GUID);
  end
endmodule

// File: rtl/guid_derive.sv
module guid_derive
  import hdr_guid_pkg::*;
#(
  parameter int UNIT_W = 4
) (
  input  logic [63:0]       base_i,
  input  logic [7:0]        count_i,
  input  logic [UNIT_W-1:0] unit_i,
  output logic              en_o,
  output logic              err_o,
  output logic [63:0]       guid_o
);
  byte_t b5, b6, b7;
  logic [8:0] s7;
  guid_t g;

  always_comb begin
    b5    = gbyte(base_i, 5);
    b6    = gbyte(base_i, 6);
    b7    = gbyte(base_i, 7);
    en_o  = (unit_i != '0) && (count_i > 8'd1) && (8'(unit_i) <= count_i);
    s7    = {1'b0, b7} + 9'(unit_i);
    g     = set_gbyte(base_i, 7, s7[7:0]);
    err_o = 1'b0;
    if (s7[8]) begin
      g = set_gbyte(g, 6, b6 + 8'd1);
      if (b6 == 8'hFF) begin
        if (b5 == 8'hFF) err_o = 1'b1;
        else             g = set_gbyte(g, 5, b5 + 8'd1);
      end
    end
    guid_o = err_o ? '0 : g;
  end
endmodule

// File: rtl/hdr_guid_check.sv
module hdr_guid_check #(
  parameter int          IDX_W        = 8,
  parameter int          UNIT_W       = 4,
  parameter int          LEN_OFS      = 0,
  parameter int          CSUM_OFS     = 1,
  parameter int          GUID_OFS     = 2,
  parameter int          CNT_OFS      = 10,
  parameter logic [63:0] DEFAULT_GUID = 64'h0000_0011_7500_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  input  logic              byte_last_i,
  input  logic [UNIT_W-1:0] unit_idx_i,
  input  logic [63:0]       base_guid_i,
  input  logic [7:0]        base_count_i,
  output logic              done_o,
  output logic              csum_ok_o,
  output logic [63:0]       guid_o,
  output logic              guid_valid_o,
  output logic              guid_default_o,
  output logic              carry_err_o,
  output logic [7:0]        guid_count_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_q;
  logic             take, fin;
  logic             sum_ok;
  logic [63:0]      raw_guid, scr_guid, der_guid;
  logic [7:0]       hdr_cnt;
  logic             scr_valid, scr_dflt, der_en, der_err;

  assign take = byte_valid_i;
  assign fin  = byte_valid_i && byte_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idx_q <= '0;
    else if (take) begin
      if (byte_last_i)        idx_q <= '0;
      else if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
    end
  end

  hdr_sum #(.IDX_W(IDX_W), .LEN_OFS(LEN_OFS), .CSUM_OFS(CSUM_OFS)) u_sum (
    .clk_i, .rst_ni, .take_i(take), .end_i(byte_last_i),
    .idx_i(idx_q), .byte_i(byte_data_i), .ok_o(sum_ok)
  );

  guid_cap #(.IDX_W(IDX_W), .GUID_OFS(GUID_OFS), .CNT_OFS(CNT_OFS)) u_cap (
    .clk_i, .rst_ni, .take_i(take), .end_i(byte_last_i),
    .idx_i(idx_q), .byte_i(byte_data_i), .guid_o(raw_guid), .cnt_o(hdr_cnt)
  );

  guid_screen #(.DEFAULT_GUID(DEFAULT_GUID)) u_scr (
    .ok_i(sum_ok), .raw_i(raw_guid),
    .valid_o(scr_valid), .dflt_o(scr_dflt), .guid_o(scr_guid)
  );

  guid_derive #(.UNIT_W(UNIT_W)) u_der (
    .base_i(base_guid_i), .count_i(base_count_i), .unit_i(unit_idx_i),
    .en_o(der_en), .err_o(der_err), .guid_o(der_guid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o         <= 1'b0;
      csum_ok_o      <= 1'b0;
      guid_o         <= '0;
      guid_valid_o   <= 1'b0;
      guid_default_o <= 1'b0;
      carry_err_o    <= 1'b0;
      guid_count_o   <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        csum_ok_o <= sum_ok;
        if (der_en) begin
          guid_o         <= der_guid;
          guid_valid_o   <= !der_err;
          guid_default_o <= 1'b0;
          carry_err_o    <= der_err;
          guid_count_o   <= der_err ? 8'd0 : 8'd1;
        end else begin
          guid_o         <= scr_guid;
          guid_valid_o   <= scr_valid;
          guid_default_o <= scr_dflt;
          carry_err_o    <= 1'b0;
          guid_count_o   <= scr_valid ? hdr_cnt : 8'd0;
        end
      end
    end
  end

  // R10
  a_r10_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && byte_last_i |=> done_o);
  a_r10_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(guid_o) && $stable(guid_valid_o) && $stable(csum_ok_o));
  // R8
  a_r8_err_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_err_o |-> guid_o == '0 && !guid_valid_o && guid_count_o == 8'd0);
  // R3
  a_r3_valid_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    guid_valid_o |-> guid_o != '0);
  // R5
  a_r5_default_is_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    guid_default_o |-> guid_valid_o && !carry_err_o);
endmodule

// File: tb/tb_hdr_guid_check.sv
module tb_hdr_guid_check;
  localparam logic [63:0] DEF = 64'h0000_0011_7500_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, lst = 1'b0;
  logic [7:0]  dat = '0;
  logic [3:0]  unit = '0;
  logic [63:0] base = '0;
  logic [7:0]  bcnt = '0;
  logic        done, ok, gval, gdef, cerr;
  logic [63:0] guid;
  logic [7:0]  gcnt;

  int n_chk = 0, n_fail = 0;
  logic [7:0] hdr [0:31];
  int hn;

  logic        e_ok, e_val, e_def, e_err;
  logic [63:0] e_guid;
  logic [7:0]  e_cnt;

  always #5 clk = ~clk;

  hdr_guid_check dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(vld), .byte_data_i(dat),
    .byte_last_i(lst), .unit_idx_i(unit), .base_guid_i(base), .base_count_i(bcnt),
    .done_o(done), .csum_ok_o(ok), .guid_o(guid), .guid_valid_o(gval),
    .guid_default_o(gdef), .carry_err_o(cerr), .guid_count_o(gcnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  // make the stored check byte consistent for length hdr[0]
  task automatic fix_sum();
    logic [7:0] t;
    t = 8'h00;
    for (int i = 0; i < hn; i++)
      if (i != 1 && i < int'(hdr[0])) t = t + hdr[i];
    hdr[1] = ~t;
  endtask

  task automatic set_guid(input logic [63:0] g);
    for (int k = 0; k < 8; k++) hdr[2+k] = g[63-8*k -: 8];
  endtask

  task automatic model();
    logic [7:0]  s, c, t;
    logic [63:0] raw;
    logic [7:0]  gb [0:7];
    int          v;
    s = 8'h00;
    for (int i = 0; i < hn; i++)
      if (i < int'(hdr[0])) s = s + hdr[i];
    c = hdr[1];
    t = s - c;
    t = ~t;
    e_ok = (t == c) && (hn >= int'(hdr[0]));
    raw = '0;
    for (int k = 0; k < 8; k++) raw = {raw[55:0], hdr[2+k]};
    if (unit != 0 && bcnt > 1 && {4'h0, unit} <= bcnt) begin
      for (int k = 0; k < 8; k++) gb[k] = base[63-8*k -: 8];
      e_err = 1'b0;
      v = int'(gb[7]) + int'(unit);
      gb[7] = 8'(v);
      if (v > 255) begin
        if (gb[6] == 8'hFF) begin
          if (gb[5] == 8'hFF) e_err = 1'b1;
          else gb[5] = gb[5] + 8'd1;
        end
        gb[6] = gb[6] + 8'd1;
      end
      e_guid = '0;
      if (!e_err) for (int k = 0; k < 8; k++) e_guid = {e_guid[55:0], gb[k]};
      e_val = !e_err;
      e_def = 1'b0;
      e_cnt = e_err ? 8'd0 : 8'd1;
    end else begin
      e_err = 1'b0;
      e_val = e_ok && raw != '0 && raw != '1;
      for (int k = 0; k < 8; k++) gb[k] = hdr[2+k];
      if (gb[0] == 0 && gb[1] == 0 && gb[2] == 0) begin
        gb[1] = gb[3]; gb[2] = gb[4]; gb[3] = 8'h00; gb[4] = 8'h00;
      end
      e_guid = '0;
      if (e_val) for (int k = 0; k < 8; k++) e_guid = {e_guid[55:0], gb[k]};
      e_def = e_val && raw == DEF;
      e_cnt = e_val ? hdr[10] : 8'd0;
    end
  endtask

  task automatic run(input string tag, input bit gaps);
    logic [63:0] g_hold;
    model();
    for (int i = 0; i < hn; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk); vld = 1'b0; dat = 8'($urandom); lst = 1'($urandom); // R12 idle beat
      end
      @(negedge clk); vld = 1'b1; dat = hdr[i]; lst = (i == hn-1);
    end
    @(negedge clk); vld = 1'b0; lst = 1'b0; dat = 8'($urandom);
    chk({tag, " R10 done"}, 64'(done), 64'd1);
    chk({tag, " R1 csum_ok"}, 64'(ok), 64'(e_ok));
    chk({tag, " R3 guid"}, guid, e_guid);
    chk({tag, " R3 guid_valid"}, 64'(gval), 64'(e_val));
    chk({tag, " R5 default"}, 64'(gdef), 64'(e_def));
    chk({tag, " R8 carry_err"}, 64'(cerr), 64'(e_err));
    chk({tag, " R9 count"}, 64'(gcnt), 64'(e_cnt));
    g_hold = guid;
    @(negedge clk);
    chk({tag, " R10 done drop"}, 64'(done), 64'd0);
    chk({tag, " R10 hold"}, guid, g_hold);
  endtask

  task automatic base_hdr(input int n, input logic [63:0] g);
    hn = n;
    for (int i = 0; i < 32; i++) hdr[i] = 8'($urandom);
    hdr[0] = 8'(n);
    set_guid(g);
    fix_sum();
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R11
    chk("R11 done", 64'(done), 64'd0);
    chk("R11 guid", guid, 64'd0);
    chk("R11 flags", {60'd0, ok, gval, gdef, cerr}, 64'd0);
    chk("R11 count", 64'(gcnt), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    base_hdr(16, 64'h1122_3344_5566_7788); run("R1 good", 1'b0);
    base_hdr(16, 64'h1122_3344_5566_7788); hdr[1] = hdr[1] ^ 8'h04; run("R1 bad sum", 1'b0);
    base_hdr(20, 64'hA1B2_C3D4_E5F6_0718); hdr[0] = 8'd14; fix_sum(); hdr[17] = hdr[17] + 8'd9;
    run("R2 tail ignored", 1'b1);
    base_hdr(12, 64'h0102_0304_0506_0708); hdr[0] = 8'd18; fix_sum(); run("R2 short", 1'b0);
    base_hdr(14, 64'h0); run("R3 zeros", 1'b0);
    base_hdr(14, 64'hFFFF_FFFF_FFFF_FFFF); run("R3 ones", 1'b0);
    base_hdr(14, 64'h0000_00AB_CD12_3456); run("R4 legacy", 1'b1);
    base_hdr(14, DEF); run("R5 default", 1'b0);
    base_hdr(14, 64'h0000_0011_7500_0002); run("R5 near default", 1'b0);

    base = 64'h0011_2233_4455_6670; bcnt = 8'd4;
    unit = 4'd3; base_hdr(12, 64'h0); run("R7 simple", 1'b0);
    base = 64'h0011_2233_44AA_10FE;
    unit = 4'd4; base_hdr(12, 64'h0); run("R7 carry6", 1'b0);
    base = 64'h0011_2233_44AA_FFFE;
    unit = 4'd2; base_hdr(12, 64'h0); run("R7 carry5", 1'b0);
    base = 64'h0011_2233_44FF_FFFF;
    unit = 4'd1; base_hdr(12, 64'h0); run("R8 overflow", 1'b0);
    unit = 4'd5; base_hdr(14, 64'h2233_4455_6677_8899); run("R6 unit above count", 1'b0);
    unit = 4'd0; base_hdr(14, 64'h2233_4455_6677_8899); run("R6 unit zero", 1'b0);
    unit = 4'd1; bcnt = 8'd1; base_hdr(14, 64'h2233_4455_6677_8899); run("R6 count one", 1'b0);

    for (int it = 0; it < 80; it++) begin
      logic [63:0] g;
      int sel;
      sel = int'($urandom % 8);
      g = {$urandom, $urandom};
      if (sel == 0) g = '0;
      if (sel == 1) g = '1;
      if (sel == 2) g[63:40] = '0;
      if (sel == 3) g = DEF;
      base_hdr(12 + int'($urandom % 20), g);
      sel = int'($urandom % 6);
      if (sel == 0) begin hdr[0] = 8'(hn - int'($urandom % 3)); fix_sum(); end
      if (sel == 1) begin hdr[0] = 8'(hn + 1 + int'($urandom % 4)); fix_sum(); end
      if (sel == 2) hdr[1] = hdr[1] + 8'd1;
      unit = 4'($urandom);
      bcnt = 8'($urandom % 20);
      base = {$urandom, $urandom};
      if ($urandom % 3 == 0) base[15:8] = 8'hFF;
      if ($urandom % 3 == 0) base[23:16] = 8'hFF;
      if ($urandom % 2 == 0) base[7:0] = 8'hF8 | 8'($urandom);
      run("R12 random", 1'b1);
    end

    summary();
    $finish;
  end
endmodule